// File: doc/BRIEF.md
# Packet DMA Channel Register Block

This block is the software-facing control and status front end of a descriptor-driven disk DMA engine with two channels. A simple register bus writes and reads each channel's control word, its event status byte, the descriptor count, the next-descriptor pointer and the two FIFO thresholds. In return the block drives the start pulse, the hold-in-reset level and the packet-mode flag of each channel's packet engine. It also gathers the engine's completion, unexpected-interrupt and parity events into a sticky status byte and one interrupt line per channel. The descriptor fetch path and the drive-side bus timing are outside the block. They appear only as event inputs and control outputs.

Each channel runs a small state machine with three states. CH_REG is plain register mode, with the engine idle. CH_PKT means the packet engine is running. CH_HOLD means the engine is held in reset. The transitions are:
- CH_REG to CH_PKT on an accepted start.
- CH_REG to CH_HOLD, and CH_PKT to CH_HOLD, on a control write with the reset bit set.
- CH_PKT to CH_REG on a completion event or a parity-error event.
- CH_HOLD to CH_REG on a control write with the reset bit clear.

A global lock byte must hold the key value before any start is honoured. Software normally locks once, sets the descriptor pointer, count and thresholds, and then writes the start bit. When the interrupt fires, it reads and clears the status byte.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, each control word reads 0x0100 (interrupt masked, PIO mode 0). Each status byte reads 0, the lock byte at 0xC7 reads 0, and irq, eng_go, eng_rst and eng_pkt are all low.
- R2: Until 0x07 is written to byte address 0xC7, a control write with the start bit (bit 7) set produces no eng_go pulse and leaves eng_pkt low. Writing any other value to 0xC7 does not lock.
- R3: Writing 0x07 to 0xC7 sets the lock, which then reads 0x07 and stays set through later writes until reset.
- R4: Once the lock is set, a control write in CH_REG with bit 7 set and bit 5 clear raises eng_go for exactly one cycle, starting the cycle after the write edge, and enters CH_PKT (eng_pkt high). The start bit always reads back as 0.
- R5: A start write that arrives while the channel is in CH_PKT produces no eng_go pulse.
- R6: A control write with bit 5 set enters CH_HOLD from any state. In CH_HOLD, eng_rst is high, eng_pkt is low and bit 5 reads back as 1. No start is accepted in CH_HOLD, even from a write that also clears bit 5. A write with bit 5 clear returns the channel to CH_REG.
- R7: A completion or parity-error event in CH_PKT returns the channel to CH_REG. A control write with only PIO bits [1:0] updates pio_mode without leaving CH_REG.
- R8: The status byte at channel offset 0x02 keeps three sticky bits: bit 6 is set by ev_done, bit 4 by ev_uirq and bit 0 by ev_perr. Each bit is independent of the other two.
- R9: A read of the status byte returns its current value and clears it. An event arriving in the same cycle as the read is kept and reads back on the next read.
- R10: irq is high exactly when the status byte is nonzero and control bit 8 (the mask) is clear.
- R11: Events that arrive while the channel is in CH_HOLD are discarded.
- R12: Channel n occupies addresses 0x80 + 0x20*n. The descriptor count is at offset 0x04, the next pointer at 0x0C, the input threshold at 0x14 and the output threshold at 0x16. These read back and drive their outputs, and a write to one channel leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on a status read) |
| bus_addr | input | 8 | Byte address of the accessed register |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |
| ev_done | input | 2 | Per-channel packet completion event |
| ev_uirq | input | 2 | Per-channel unexpected device interrupt event |
| ev_perr | input | 2 | Per-channel host bus parity error event |
| eng_go | output | 2 | One-cycle start pulse per channel |
| eng_rst | output | 2 | Engine held in reset per channel |
| eng_pkt | output | 2 | Packet engine running per channel |
| irq | output | 2 | Interrupt per channel |
| pio_mode | output | 4 | Two-bit PIO mode per channel |
| cpb_count | output | 32 | 16-bit descriptor count per channel |
| next_cpb | output | 64 | 32-bit next-descriptor pointer per channel |
| fifo_in_thr | output | 32 | 16-bit input FIFO threshold per channel |
| fifo_out_thr | output | 32 | 16-bit output FIFO threshold per channel |

## Verification
Several properties are checked on every cycle:
- a start pulse never lasts two cycles;
- a start pulse never appears without the lock, and always coincides with packet mode;
- no start follows a cycle spent in reset hold;
- the lock never drops;
- a status bit that is not being cleared stays set;
- a masked channel never raises its interrupt.

Other behaviour can only be shown by the directed scenarios:
- the exact address decode and readback values;
- clear-on-read, including an event that collides with the read;
- discarding of events during reset hold;
- the return to register mode after completion;
- independence of the two channels.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CH_BASE  = 'h80;
    localparam int CH_SHIFT = 5;          // 0x20 stride between channels

    localparam logic [7:0] LOCK_ADDR = 8'hC7;
    localparam logic [7:0] LOCK_KEY  = 8'h07;

    // channel register offsets
    localparam logic [CH_SHIFT-1:0] OFF_CTRL = 5'h00;
    localparam logic [CH_SHIFT-1:0] OFF_STAT = 5'h02;
    localparam logic [CH_SHIFT-1:0] OFF_CNT  = 5'h04;
    localparam logic [CH_SHIFT-1:0] OFF_PTR  = 5'h0C;
    localparam logic [CH_SHIFT-1:0] OFF_FIN  = 5'h14;
    localparam logic [CH_SHIFT-1:0] OFF_FOUT = 5'h16;

    // control word bits
    localparam int B_MASK = 8;
    localparam int B_GO   = 7;
    localparam int B_RST  = 5;

    // status byte bits
    localparam int S_DONE = 6;
    localparam int S_UIRQ = 4;
    localparam int S_PERR = 0;
    localparam int ST_W   = 8;

    typedef enum logic [1:0] {
        CH_REG  = 2'd0,
        CH_HOLD = 2'd1,
        CH_PKT  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/dma_mode_lock.sv
module dma_mode_lock
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wbyte,
    output logic       locked
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (wr && (wbyte == LOCK_KEY)) begin
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dma_chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_done,
    input  logic            ev_uirq,
    input  logic            ev_perr,
    input  logic            drop,
    input  logic            clr,
    output logic [ST_W-1:0] st
);

    logic [ST_W-1:0] st_n;

    always_comb begin
        st_n = clr ? '0 : st;
        if (!drop) begin
            st_n[S_DONE] = st_n[S_DONE] | ev_done;
            st_n[S_UIRQ] = st_n[S_UIRQ] | ev_uirq;
            st_n[S_PERR] = st_n[S_PERR] | ev_perr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st <= st_n;
        end
    end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PTR_W = 32,
    parameter int THR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_en,
    input  logic              wr_ctrl,
    input  logic              wr_cnt,
    input  logic              wr_ptr,
    input  logic              wr_fin,
    input  logic              wr_fout,
    input  logic [DATA_W-1:0] wdata,
    input  logic              end_evt,
    output logic              eng_go,
    output logic              eng_rst,
    output logic              eng_pkt,
    output logic              irq_mask,
    output logic [1:0]        pio,
    output logic [15:0]       ctrl_rd,
    output logic [CNT_W-1:0]  count,
    output logic [PTR_W-1:0]  ptr,
    output logic [THR_W-1:0]  fin,
    output logic [THR_W-1:0]  fout
);

    ch_state_e state, state_n;
    logic      go_acc;
    logic      go_q;
    logic      rst_req;
    logic      go_req;

    assign rst_req = wr_ctrl && wdata[B_RST];
    assign go_req  = wr_ctrl && wdata[B_GO] && !wdata[B_RST] && lock_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_REG;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        go_acc  = 1'b0;
        unique case (state)
            CH_REG: begin
                if (rst_req) begin
                    state_n = CH_HOLD;
                end else if (go_req) begin
                    state_n = CH_PKT;
                    go_acc  = 1'b1;
                end
            end
            CH_PKT: begin
                if (rst_req) begin
                    state_n = CH_HOLD;
                end else if (end_evt) begin
                    state_n = CH_REG;
                end
            end
            CH_HOLD: begin
                if (wr_ctrl && !wdata[B_RST]) begin
                    state_n = CH_REG;
                end
            end
            default: state_n = CH_REG;
        endcase
    end

    // outputs
    always_comb begin
        eng_rst = (state == CH_HOLD);
        eng_pkt = (state == CH_PKT);
        eng_go  = go_q;
        ctrl_rd = '0;
        ctrl_rd[B_MASK] = irq_mask;
        ctrl_rd[B_RST]  = (state == CH_HOLD);
        ctrl_rd[1:0]    = pio;
    end

    // configuration and control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q     <= 1'b0;
            irq_mask <= 1'b1;
            pio      <= 2'd0;
            count    <= '0;
            ptr      <= '0;
            fin      <= '0;
            fout     <= '0;
        end else begin
            go_q <= go_acc;
            if (wr_ctrl) begin
                irq_mask <= wdata[B_MASK];
                pio      <= wdata[1:0];
            end
            if (wr_cnt)  count <= wdata[CNT_W-1:0];
            if (wr_ptr)  ptr   <= wdata[PTR_W-1:0];
            if (wr_fin)  fin   <= wdata[THR_W-1:0];
            if (wr_fout) fout  <= wdata[THR_W-1:0];
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int CNT_W = 16,
    parameter int PTR_W = 32,
    parameter int THR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [N_CH-1:0]         ev_done,
    input  logic [N_CH-1:0]         ev_uirq,
    input  logic [N_CH-1:0]         ev_perr,
    output logic [N_CH-1:0]         eng_go,
    output logic [N_CH-1:0]         eng_rst,
    output logic [N_CH-1:0]         eng_pkt,
    output logic [N_CH-1:0]         irq,
    output logic [2*N_CH-1:0]       pio_mode,
    output logic [CNT_W*N_CH-1:0]   cpb_count,
    output logic [PTR_W*N_CH-1:0]   next_cpb,
    output logic [THR_W*N_CH-1:0]   fifo_in_thr,
    output logic [THR_W*N_CH-1:0]   fifo_out_thr
);

    localparam int BLK_W    = ADDR_W - CH_SHIFT;
    localparam int BLK_BASE = CH_BASE >> CH_SHIFT;

    logic                  lock_q;
    logic [N_CH-1:0]       mask_v;
    logic [N_CH-1:0]       st_clr_v;
    logic [N_CH-1:0]       hit_v;
    logic [ST_W*N_CH-1:0]  st_flat;
    logic [15:0]           ctrl_rd_a [N_CH];
    logic [CH_SHIFT-1:0]   off;

    assign off = bus_addr[CH_SHIFT-1:0];

    dma_mode_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr && (bus_addr == LOCK_ADDR)),
        .wbyte  (bus_wdata[7:0]),
        .locked (lock_q)
    );

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        localparam logic [BLK_W-1:0] BLK = BLK_W'(BLK_BASE + gi);
        logic wr_hit;
        logic stat_end;

        assign hit_v[gi]    = (bus_addr[ADDR_W-1:CH_SHIFT] == BLK);
        assign wr_hit       = bus_wr && hit_v[gi];
        assign st_clr_v[gi] = bus_rd && hit_v[gi] && (off == OFF_STAT);
        assign stat_end     = ev_done[gi] | ev_perr[gi];

        dma_chan_ctl #(
            .CNT_W (CNT_W),
            .PTR_W (PTR_W),
            .THR_W (THR_W)
        ) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .lock_en  (lock_q),
            .wr_ctrl  (wr_hit && (off == OFF_CTRL)),
            .wr_cnt   (wr_hit && (off == OFF_CNT)),
            .wr_ptr   (wr_hit && (off == OFF_PTR)),
            .wr_fin   (wr_hit && (off == OFF_FIN)),
            .wr_fout  (wr_hit && (off == OFF_FOUT)),
            .wdata    (bus_wdata),
            .end_evt  (stat_end),
            .eng_go   (eng_go[gi]),
            .eng_rst  (eng_rst[gi]),
            .eng_pkt  (eng_pkt[gi]),
            .irq_mask (mask_v[gi]),
            .pio      (pio_mode[2*gi +: 2]),
            .ctrl_rd  (ctrl_rd_a[gi]),
            .count    (cpb_count[CNT_W*gi +: CNT_W]),
            .ptr      (next_cpb[PTR_W*gi +: PTR_W]),
            .fin      (fifo_in_thr[THR_W*gi +: THR_W]),
            .fout     (fifo_out_thr[THR_W*gi +: THR_W])
        );

        dma_chan_status u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_done (ev_done[gi]),
            .ev_uirq (ev_uirq[gi]),
            .ev_perr (ev_perr[gi]),
            .drop    (eng_rst[gi]),
            .clr     (st_clr_v[gi]),
            .st      (st_flat[ST_W*gi +: ST_W])
        );

        assign irq[gi] = (|st_flat[ST_W*gi +: ST_W]) && !mask_v[gi];
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == LOCK_ADDR) begin
            bus_rdata = lock_q ? DATA_W'(LOCK_KEY) : '0;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (hit_v[i]) begin
                case (off)
                    OFF_CTRL: bus_rdata = DATA_W'(ctrl_rd_a[i]);
                    OFF_STAT: bus_rdata = DATA_W'(st_flat[ST_W*i +: ST_W]);
                    OFF_CNT:  bus_rdata = DATA_W'(cpb_count[CNT_W*i +: CNT_W]);
                    OFF_PTR:  bus_rdata = DATA_W'(next_cpb[PTR_W*i +: PTR_W]);
                    OFF_FIN:  bus_rdata = DATA_W'(fifo_in_thr[THR_W*i +: THR_W]);
                    OFF_FOUT: bus_rdata = DATA_W'(fifo_out_thr[THR_W*i +: THR_W]);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int N_CH = 2,
    parameter int ST_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CH-1:0]      eng_go,
    input logic [N_CH-1:0]      eng_rst,
    input logic [N_CH-1:0]      eng_pkt,
    input logic [N_CH-1:0]      irq,
    input logic                 locked,
    input logic [N_CH-1:0]      ctrl_mask,
    input logic [ST_W*N_CH-1:0] st_flat,
    input logic [N_CH-1:0]      st_clr
);

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_a
        assert_go_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
            eng_go[gi] |=> !eng_go[gi]);

        assert_go_with_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
            eng_go[gi] |-> eng_pkt[gi]);

        assert_go_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
            eng_go[gi] |-> locked);

        assert_no_go_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            eng_rst[gi] |=> !eng_go[gi]);

        assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_mask[gi] |-> !irq[gi]);

        for (genvar gb = 0; gb < ST_W; gb++) begin : g_b
            assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (st_flat[ST_W*gi + gb] && !st_clr[gi]) |=> st_flat[ST_W*gi + gb]);
        end
    end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.N_CH(N_CH), .ST_W(8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_go    (eng_go),
    .eng_rst   (eng_rst),
    .eng_pkt   (eng_pkt),
    .irq       (irq),
    .locked    (lock_q),
    .ctrl_mask (mask_v),
    .st_flat   (st_flat),
    .st_clr    (st_clr_v)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [1:0]  ev_done = 2'b00;
    logic [1:0]  ev_uirq = 2'b00;
    logic [1:0]  ev_perr = 2'b00;
    logic [1:0]  eng_go, eng_rst, eng_pkt, irq;
    logic [3:0]  pio_mode;
    logic [31:0] cpb_count;
    logic [63:0] next_cpb;
    logic [31:0] fifo_in_thr, fifo_out_thr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dma_chan_regs u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ev_done      (ev_done),
        .ev_uirq      (ev_uirq),
        .ev_perr      (ev_perr),
        .eng_go       (eng_go),
        .eng_rst      (eng_rst),
        .eng_pkt      (eng_pkt),
        .irq          (irq),
        .pio_mode     (pio_mode),
        .cpb_count    (cpb_count),
        .next_cpb     (next_cpb),
        .fifo_in_thr  (fifo_in_thr),
        .fifo_out_thr (fifo_out_thr)
    );

    localparam logic [7:0] C0 = 8'h80;
    localparam logic [7:0] C1 = 8'hA0;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int ch, input int kind);
        @(negedge clk);
        if (kind == 0) ev_done[ch] = 1'b1;
        if (kind == 1) ev_uirq[ch] = 1'b1;
        if (kind == 2) ev_perr[ch] = 1'b1;
        @(negedge clk);
        ev_done = 2'b00; ev_uirq = 2'b00; ev_perr = 2'b00;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(C0, d);          check(d, 32'h0100, "R1 ctrl");
        bus_read(C0 + 8'h02, d);  check(d, 32'h0, "R1 status");
        bus_read(8'hC7, d);       check(d, 32'h0, "R1 lock");
        check({irq, eng_go, eng_rst, eng_pkt}, 8'h00, "R1 outputs");
    endtask

    task automatic t_lock();
        logic [31:0] d;
        bus_write(C0, 32'h0083);
        check(eng_go, 2'b00, "R2 go before lock");
        check(eng_pkt, 2'b00, "R2 pkt before lock");
        bus_write(8'hC7, 32'h05);
        bus_read(8'hC7, d);       check(d, 32'h0, "R2 wrong key");
        bus_write(8'hC7, 32'h07);
        bus_read(8'hC7, d);       check(d, 32'h7, "R3 locked");
        bus_write(8'hC7, 32'h00);
        bus_read(8'hC7, d);       check(d, 32'h7, "R3 lock sticky");
    endtask

    task automatic t_go();
        logic [31:0] d;
        bus_write(C0, 32'h0083);
        check(eng_go, 2'b01, "R4 go pulse");
        check(eng_pkt, 2'b01, "R4 pkt mode");
        @(negedge clk);
        check(eng_go, 2'b00, "R4 go one cycle");
        bus_read(C0, d);          check(d, 32'h0003, "R4 go reads 0");
        bus_write(C0, 32'h0083);
        check(eng_go, 2'b00, "R5 go while busy");
        pulse(0, 0);
        check(eng_pkt, 2'b00, "R7 done ends pkt");
        check(irq, 2'b01, "R10 irq on");
        bus_read(C0 + 8'h02, d);  check(d, 32'h40, "R8 done bit");
        check(irq, 2'b00, "R9 irq after clear");
        bus_read(C0 + 8'h02, d);  check(d, 32'h0, "R9 cleared");
    endtask

    task automatic t_status();
        logic [31:0] d;
        pulse(0, 1);
        pulse(0, 2);
        bus_read(C0 + 8'h02, d);  check(d, 32'h11, "R8 uirq+perr");
        bus_read(C0 + 8'h02, d);  check(d, 32'h0, "R9 cleared twice");
        bus_read(C1 + 8'h02, d);  check(d, 32'h0, "R12 ch1 status untouched");
        bus_write(C0, 32'h0103);
        pulse(0, 1);
        check(irq, 2'b00, "R10 masked");
        bus_read(C0 + 8'h02, d);  check(d, 32'h10, "R10 masked still sticky");
        pulse(0, 1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = C0 + 8'h02; ev_done[0] = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; ev_done = 2'b00;
        check(d, 32'h10, "R9 read in collision");
        bus_read(C0 + 8'h02, d);  check(d, 32'h40, "R9 colliding event kept");
        bus_write(C0, 32'h0003);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        bus_write(C0, 32'h0023);
        check({eng_rst[0], eng_pkt[0]}, 2'b10, "R6 hold");
        bus_read(C0, d);          check(d, 32'h0023, "R6 rst readback");
        bus_write(C0, 32'h00A3);
        check(eng_go, 2'b00, "R6 go with reset");
        pulse(0, 1);
        bus_write(C0, 32'h0003);
        check(eng_rst, 2'b00, "R6 release");
        bus_read(C0 + 8'h02, d);  check(d, 32'h0, "R11 dropped in hold");
        bus_write(C0, 32'h0083);
        check(eng_go, 2'b01, "R4 go after release");
        bus_write(C0, 32'h0023);
        check({eng_rst[0], eng_pkt[0]}, 2'b10, "R6 hold from pkt");
        bus_write(C0, 32'h0083);
        check({eng_go[0], eng_rst[0], eng_pkt[0]}, 3'b000, "R6 release with go ignored");
        bus_write(C0, 32'h0002);
        check(pio_mode[1:0], 2'd2, "R7 pio mode out");
        check(eng_pkt, 2'b00, "R7 stays reg mode");
        bus_read(C0, d);          check(d, 32'h0002, "R7 pio readback");
        bus_write(C0, 32'h0083);
        pulse(0, 2);
        check(eng_pkt, 2'b00, "R7 perr ends pkt");
        bus_read(C0 + 8'h02, d);  check(d, 32'h01, "R8 perr bit");
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        bus_write(C0 + 8'h04, 32'h0001);
        bus_write(C0 + 8'h0C, 32'h1234_5678);
        bus_write(C0 + 8'h14, 32'h0100);
        bus_write(C0 + 8'h16, 32'h0080);
        bus_read(C0 + 8'h04, d);  check(d, 32'h0001, "R12 count");
        bus_read(C0 + 8'h0C, d);  check(d, 32'h1234_5678, "R12 ptr");
        bus_read(C0 + 8'h14, d);  check(d, 32'h0100, "R12 fin");
        bus_read(C0 + 8'h16, d);  check(d, 32'h0080, "R12 fout");
        check(next_cpb[31:0], 32'h1234_5678, "R12 ptr out");
        check({fifo_out_thr[15:0], fifo_in_thr[15:0]}, 32'h0080_0100, "R12 thr out");
        bus_write(C1 + 8'h04, 32'h0005);
        check(cpb_count, 32'h0005_0001, "R12 channel split");
        bus_write(C1, 32'h0083);
        check(eng_go, 2'b10, "R12 ch1 go");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_go();
        t_status();
        t_hold();
        t_cfg();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule